// File: doc/BRIEF.md
# DAC Serial Data-Out Path (Readback and Daisy-Chain)

This block forms the serial output side of a DAC control port that takes 16-bit frames. A host clocks frames in on `din` with `sclk` while `cs_n` is held low, and each bit is sampled on the falling `sclk` edge. The block keeps the input shift register and a frame counter. It also recognises read commands and holds the selected channel code in a holding register. It drives one output pin, `sdo`, and that pin's enable, `sdo_oe`, in one of three ways. In readback mode the pin shifts out the held code during the frame that follows the read command, and the pin is released when idle. In the two daisy-chain modes the pin copies the live shift register contents 16 bits late, so that a second device can sit behind this one. The daisy-chain pin idles driven high.

All inputs are taken as synchronous to `clk`, and edges of `sclk` and `cs_n` are found by comparing each input with its value one cycle earlier. A frame state machine tracks each frame through three states. FR_IDLE means `cs_n` is high. FR_SHIFT means `cs_n` is low and fewer than 16 bits have arrived. FR_FULL means 16 or more bits have arrived and the counter has saturated. There are four transitions:
- FR_IDLE to FR_SHIFT when `cs_n` goes low.
- FR_SHIFT to FR_FULL on the 16th falling edge.
- FR_SHIFT to FR_IDLE when `cs_n` rises.
- FR_FULL to FR_IDLE when `cs_n` rises.

The end of a frame is marked in one of two places. With `eoc_at_edge` low it is the rise of `cs_n`. With `eoc_at_edge` high it is the 16th falling edge.

Top module: `dac_sdo_path`

## Requirements
- R1: While `cs_n` is low, each falling `sclk` edge shifts `din` into the frame, first bit most significant. The bit count saturates at 16 and returns to 0 whenever `cs_n` is high.
- R2: With `eoc_at_edge`=0, `eoc` pulses for one `clk` cycle after `cs_n` rises on a frame of 16 or more bits, and never while `cs_n` is low. With `eoc_at_edge`=1, `eoc` pulses for one cycle right after the 16th falling edge.
- R3: A frame that ends after fewer than 16 falling edges gives no `eoc` pulse and loads nothing.
- R4: A frame is a read command when its word bits [15:12] equal 4'b1001. Bits [11:10] then pick a channel, where channel c is `chan_codes[12*c+11:12*c]`. The decoded word is the first 16 bits when `eoc_at_edge`=1 and the last 16 bits when `eoc_at_edge`=0. At end of frame the holding register loads {code, 4'b0000}.
- R5: With `pin_mode`=2'b00 (readback), the frame that follows a loaded read drives `sdo_oe`=1 from the fall of `cs_n`. `sdo` shows holding bit 15 first and advances one bit after each falling edge. It shows 0 once all 16 bits are out.
- R6: Loaded readback data is used up at the next fall of `cs_n`, whatever the pin mode. A readback-mode frame that has no loaded data keeps `sdo_oe`=0 for the whole frame.
- R7: In readback mode, `sdo_oe`=0 and `sdo`=0 whenever `cs_n` is high, including straight after reset.
- R8: In both daisy-chain modes (`pin_mode` 2'b01 or 2'b10), `sdo` carries the bit shifted in 16 falling edges earlier. It stays 1 until 16 bits of the current frame have arrived.
- R9: In daisy-chain mode 2'b01, `sdo` changes right after the falling `sclk` edge.
- R10: In daisy-chain mode 2'b10, `sdo` changes right after the rising `sclk` edge, half a bit later than in mode 2'b01.
- R11: In both daisy-chain modes, `sdo_oe`=1 and `sdo`=1 whenever `cs_n` is high.
- R12: `pin_mode`=2'b11 disables the pin: `sdo_oe`=0 and `sdo`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all inputs are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; it idles high |
| cs_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial data in, sampled on falling `sclk` |
| pin_mode | input | 2 | 00 readback, 01 daisy-chain on falling edge, 10 daisy-chain on rising edge, 11 off |
| eoc_at_edge | input | 1 | 1: end of frame is the 16th falling edge; 0: it is the rise of `cs_n` |
| chan_codes | input | 48 | Four 12-bit channel codes; channel c sits at bits 12c+11:12c |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` (0 = high impedance) |
| eoc | output | 1 | One-cycle end-of-frame strobe |

## Verification
Frames of exactly 16 bits, frames that are too short, and frames of 20 to 32 bits are sent in every pin mode. Long frames are what tell a delayed daisy-chain copy apart from a stuck or unshifted one. They also separate first-16 decoding from last-16 decoding, because a read header is placed at only one of the two positions. The pin is sampled in both the low and the high half of each `sclk` period, which is the only place where the falling-edge and rising-edge daisy variants differ. Readback is exercised for every channel, both right after a read frame and one frame later, to show that loaded data is used up at the next fall of `cs_n`. Random frames with random headers, lengths and modes then compare the pin against a bench model of the frame.

// File: rtl/dac_sdo_pkg.sv
`timescale 1ns/1ps
package dac_sdo_pkg;

    typedef enum logic [1:0] {
        PIN_RDBK    = 2'b00,
        PIN_DC_FALL = 2'b01,
        PIN_DC_RISE = 2'b10,
        PIN_OFF     = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'b00,
        FR_SHIFT = 2'b01,
        FR_FULL  = 2'b10
    } frame_st_e;

endpackage

// File: rtl/dac_sdo_edge.sv
`timescale 1ns/1ps
module dac_sdo_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    output logic sclk_fall,
    output logic sclk_rise,
    output logic sel_fall,
    output logic sel_rise
);

    logic sclk_q;
    logic cs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b1;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
        end
    end

    // serial clock edges only count inside a selected frame
    assign sclk_fall = sclk_q & ~sclk & ~cs_n;
    assign sclk_rise = ~sclk_q & sclk & ~cs_n;
    assign sel_fall  = cs_q & ~cs_n;
    assign sel_rise  = ~cs_q & cs_n;

endmodule

// File: rtl/dac_sdo_frame_fsm.sv
`timescale 1ns/1ps
module dac_sdo_frame_fsm #(
    parameter int FRAME_BITS = 16,
    parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk_fall,
    input  logic             sel_rise,
    input  logic             eoc_at_edge,
    output logic [CNT_W-1:0] bit_cnt,
    output logic             frame_full,
    output logic             last_edge,
    output logic             eoc_evt,
    output logic             eoc_q
);
    import dac_sdo_pkg::*;

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS);

    frame_st_e st_q, st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FR_IDLE;
        else        st_q <= st_d;
    end

    assign last_edge = sclk_fall && (bit_cnt == CNT_LAST);

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FR_IDLE:  if (!cs_n) st_d = FR_SHIFT;
            FR_SHIFT: begin
                if (cs_n)           st_d = FR_IDLE;
                else if (last_edge) st_d = FR_FULL;
            end
            FR_FULL:  if (cs_n) st_d = FR_IDLE;
            default:  st_d = FR_IDLE;
        endcase
    end

    // end-of-frame event: 16th falling edge or select release after a full frame
    always_comb begin
        if (eoc_at_edge) eoc_evt = last_edge && (st_q != FR_FULL);
        else             eoc_evt = sel_rise && (st_q == FR_FULL);
    end

    // registered outputs: bit counter and strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            eoc_q   <= 1'b0;
        end else begin
            eoc_q <= eoc_evt;
            if (cs_n)
                bit_cnt <= '0;
            else if (sclk_fall && (bit_cnt < CNT_MAX))
                bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign frame_full = (st_q == FR_FULL);

endmodule

// File: rtl/dac_sdo_rdbk.sv
`timescale 1ns/1ps
module dac_sdo_rdbk #(
    parameter int          FRAME_BITS = 16,
    parameter int          CODE_W     = 12,
    parameter int          NUM_CH     = 4,
    parameter int          CMD_W      = 4,
    parameter logic [3:0]  CMD_READ   = 4'b1001
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     sel_fall,
    input  logic                     sclk_fall,
    input  logic                     load_evt,
    input  logic [FRAME_BITS-1:0]    frame_word,
    input  logic [NUM_CH*CODE_W-1:0] chan_codes,
    output logic                     rb_active,
    output logic                     rb_bit
);

    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int PAD   = FRAME_BITS - CODE_W;

    logic [CODE_W-1:0]     code_arr [NUM_CH];
    logic [FRAME_BITS-1:0] hold_q;
    logic [FRAME_BITS-1:0] out_sr;
    logic                  pend_q;
    logic [SEL_W-1:0]      ch_sel;
    logic                  is_read;
    logic [FRAME_BITS-1:0] hold_d;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_code
        assign code_arr[c] = chan_codes[c*CODE_W +: CODE_W];
    end

    assign is_read = (frame_word[FRAME_BITS-1 -: CMD_W] == CMD_READ[CMD_W-1:0]);
    assign ch_sel  = frame_word[FRAME_BITS-CMD_W-1 -: SEL_W];
    assign hold_d  = FRAME_BITS'(code_arr[ch_sel]) << PAD;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q    <= '0;
            pend_q    <= 1'b0;
            out_sr    <= '0;
            rb_active <= 1'b0;
        end else begin
            if (load_evt && is_read) begin
                hold_q <= hold_d;
                pend_q <= 1'b1;
            end else if (sel_fall) begin
                pend_q <= 1'b0;
            end

            if (sel_fall) begin
                rb_active <= pend_q;
                out_sr    <= hold_q;
            end else if (cs_n) begin
                rb_active <= 1'b0;
            end else if (sclk_fall && rb_active) begin
                out_sr <= out_sr << 1;
            end
        end
    end

    assign rb_bit = out_sr[FRAME_BITS-1];

endmodule

// File: rtl/dac_sdo_dchain.sv
`timescale 1ns/1ps
module dac_sdo_dchain (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk_rise,
    input  logic frame_full,
    input  logic sr_msb,
    output logic dc_fall_bit,
    output logic dc_rise_bit
);

    logic rise_vld;
    logic rise_q;

    // falling variant: follows the shift register, which moves on falling edges
    assign dc_fall_bit = frame_full ? sr_msb : 1'b1;

    // rising variant: retimes the same bit on the next rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_vld <= 1'b0;
            rise_q   <= 1'b1;
        end else if (cs_n) begin
            rise_vld <= 1'b0;
            rise_q   <= 1'b1;
        end else if (sclk_rise && frame_full) begin
            rise_vld <= 1'b1;
            rise_q   <= sr_msb;
        end
    end

    assign dc_rise_bit = rise_vld ? rise_q : 1'b1;

endmodule

// File: rtl/dac_sdo_path.sv
`timescale 1ns/1ps
module dac_sdo_path #(
    parameter int FRAME_BITS = 16,
    parameter int CODE_W     = 12,
    parameter int NUM_CH     = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sclk,
    input  logic                     cs_n,
    input  logic                     din,
    input  logic [1:0]               pin_mode,
    input  logic                     eoc_at_edge,
    input  logic [NUM_CH*CODE_W-1:0] chan_codes,
    output logic                     sdo,
    output logic                     sdo_oe,
    output logic                     eoc
);
    import dac_sdo_pkg::*;

    localparam int CNT_W = $clog2(FRAME_BITS + 1);

    logic                  sclk_fall, sclk_rise, sel_fall, sel_rise;
    logic [CNT_W-1:0]      frame_cnt;
    logic                  frame_full, last_edge, eoc_evt;
    logic [FRAME_BITS-1:0] shift_q;
    logic [FRAME_BITS-1:0] frame_word;
    logic                  rb_active, rb_bit;
    logic                  dc_fall_bit, dc_rise_bit;
    pin_mode_e             pm;

    dac_sdo_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sclk_fall (sclk_fall),
        .sclk_rise (sclk_rise),
        .sel_fall  (sel_fall),
        .sel_rise  (sel_rise)
    );

    dac_sdo_frame_fsm #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sclk_fall   (sclk_fall),
        .sel_rise    (sel_rise),
        .eoc_at_edge (eoc_at_edge),
        .bit_cnt     (frame_cnt),
        .frame_full  (frame_full),
        .last_edge   (last_edge),
        .eoc_evt     (eoc_evt),
        .eoc_q       (eoc)
    );

    // input shift register, keeps shifting past the frame length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         shift_q <= '0;
        else if (sclk_fall) shift_q <= {shift_q[FRAME_BITS-2:0], din};
    end

    // word seen at end of frame: includes the bit landing on the 16th edge
    assign frame_word = eoc_at_edge ? {shift_q[FRAME_BITS-2:0], din} : shift_q;

    dac_sdo_rdbk #(.FRAME_BITS(FRAME_BITS), .CODE_W(CODE_W), .NUM_CH(NUM_CH)) u_rdbk (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sel_fall   (sel_fall),
        .sclk_fall  (sclk_fall),
        .load_evt   (eoc_evt),
        .frame_word (frame_word),
        .chan_codes (chan_codes),
        .rb_active  (rb_active),
        .rb_bit     (rb_bit)
    );

    dac_sdo_dchain u_dchain (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sclk_rise   (sclk_rise),
        .frame_full  (frame_full),
        .sr_msb      (shift_q[FRAME_BITS-1]),
        .dc_fall_bit (dc_fall_bit),
        .dc_rise_bit (dc_rise_bit)
    );

    assign pm = pin_mode_e'(pin_mode);

    // pin driver
    always_comb begin
        sdo_oe = 1'b0;
        sdo    = 1'b0;
        unique case (pm)
            PIN_RDBK: begin
                sdo_oe = !cs_n && rb_active;
                sdo    = !cs_n && rb_active && rb_bit;
            end
            PIN_DC_FALL: begin
                sdo_oe = 1'b1;
                sdo    = cs_n ? 1'b1 : dc_fall_bit;
            end
            PIN_DC_RISE: begin
                sdo_oe = 1'b1;
                sdo    = cs_n ? 1'b1 : dc_rise_bit;
            end
            PIN_OFF: begin
                sdo_oe = 1'b0;
                sdo    = 1'b0;
            end
            default: begin
                sdo_oe = 1'b0;
                sdo    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dac_sdo_path_chk.sv
`timescale 1ns/1ps
module dac_sdo_path_chk #(
    parameter int FRAME_BITS = 16,
    parameter int CNT_W      = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic [1:0]       pin_mode,
    input logic             eoc_at_edge,
    input logic             sdo,
    input logic             sdo_oe,
    input logic             eoc,
    input logic [CNT_W-1:0] frame_cnt
);

    p_cnt_sat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_cnt <= CNT_W'(FRAME_BITS));

    p_eoc_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> !eoc);

    p_eoc_after_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && !$past(eoc_at_edge)) |-> $past(cs_n));

    p_rb_idle_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_mode == 2'b00 && cs_n) |-> (!sdo_oe && !sdo));

    p_dc_pre_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_mode == 2'b01 || pin_mode == 2'b10) && !cs_n
         && frame_cnt < CNT_W'(FRAME_BITS)) |-> sdo);

    p_dc_idle_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_mode == 2'b01 || pin_mode == 2'b10) && cs_n) |-> (sdo_oe && sdo));

    p_pin_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_mode == 2'b11) |-> (!sdo_oe && !sdo));

endmodule

bind dac_sdo_path dac_sdo_path_chk #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .pin_mode    (pin_mode),
    .eoc_at_edge (eoc_at_edge),
    .sdo         (sdo),
    .sdo_oe      (sdo_oe),
    .eoc         (eoc),
    .frame_cnt   (frame_cnt)
);

// File: tb/dac_sdo_path_bench.sv
`timescale 1ns/1ps
module dac_sdo_path_bench;

    localparam int HP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        cs_n = 1'b1;
    logic        din = 1'b0;
    logic [1:0]  pin_mode = 2'b00;
    logic        eoc_at_edge = 1'b0;
    logic [47:0] chan_codes = '0;
    logic        sdo, sdo_oe, eoc;

    int checks = 0;
    int fails  = 0;
    int eoc_cnt = 0;
    bit done = 1'b0;

    bit          rb_pend = 1'b0;
    logic [15:0] rb_word = '0;

    always #2.5 clk = ~clk;

    always @(posedge clk) if (eoc) eoc_cnt <= eoc_cnt + 1;

    dac_sdo_path u_dac_sdo_path (
        .clk (clk), .rst_n (rst_n), .sclk (sclk), .cs_n (cs_n), .din (din),
        .pin_mode (pin_mode), .eoc_at_edge (eoc_at_edge), .chan_codes (chan_codes),
        .sdo (sdo), .sdo_oe (sdo_oe), .eoc (eoc)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [11:0] code_of(input logic [1:0] ch);
        return chan_codes[ch*12 +: 12];
    endfunction

    // k = falling edges so far; low_ph = sampled between fall k and rise k
    task automatic check_pin(input int k, input bit low_ph, input logic [31:0] v,
                             input bit act, input logic [15:0] ow);
        logic eo, es;
        int   kk;
        string req;
        case (pin_mode)
            2'b00: begin
                eo  = act;
                es  = act ? ((k < 16) ? ow[15-k] : 1'b0) : 1'b0;
                req = act ? "R5" : "R6";
            end
            2'b01: begin
                eo  = 1'b1;
                es  = (k >= 16) ? v[31-(k-16)] : 1'b1;
                req = (k >= 16) ? "R9" : "R8";
            end
            2'b10: begin
                kk  = low_ph ? k - 1 : k;
                eo  = 1'b1;
                es  = (kk >= 16) ? v[31-(kk-16)] : 1'b1;
                req = (kk >= 16) ? "R10" : "R8";
            end
            default: begin
                eo  = 1'b0;
                es  = 1'b0;
                req = "R12";
            end
        endcase
        chk(req, "sdo_oe", {31'd0, sdo_oe}, {31'd0, eo});
        if (eo) chk(req, "sdo", {31'd0, sdo}, {31'd0, es});
    endtask

    // send n bits, bit i = v[31-i]
    task automatic run_frame(input logic [31:0] v, input int n);
        bit          act;
        logic [15:0] ow, w;
        int          e0;
        act = rb_pend;
        ow  = rb_word;
        rb_pend = 1'b0;
        e0 = eoc_cnt;
        cs_n = 1'b0;
        wait_clk(HP);
        check_pin(0, 1'b0, v, act, ow);
        for (int i = 0; i < n; i++) begin
            din = v[31-i];
            wait_clk(HP);
            sclk = 1'b0;
            wait_clk(HP);
            check_pin(i + 1, 1'b1, v, act, ow);
            if (i + 1 == 16 && eoc_at_edge)
                chk("R2", "eoc at 16th edge", eoc_cnt - e0, 1);  // R2
            sclk = 1'b1;
            wait_clk(HP);
            check_pin(i + 1, 1'b0, v, act, ow);
        end
        if (!eoc_at_edge) chk("R2", "no eoc while selected", eoc_cnt - e0, 0);
        cs_n = 1'b1;
        wait_clk(HP);
        if (n >= 16) chk("R2", "eoc count per frame", eoc_cnt - e0, 1);
        else         chk("R3", "short frame eoc", eoc_cnt - e0, 0);
        // idle pin
        if (pin_mode == 2'b00) begin
            chk("R7", "idle oe", {31'd0, sdo_oe}, 0);
        end else if (pin_mode == 2'b11) begin
            chk("R12", "idle oe", {31'd0, sdo_oe}, 0);
        end else begin
            chk("R11", "idle oe", {31'd0, sdo_oe}, 1);
            chk("R11", "idle sdo", {31'd0, sdo}, 1);
        end
        // model the holding register (R4)
        if (n >= 16) begin
            w = eoc_at_edge ? v[31:16] : v[31-(n-16) -: 16];
            if (w[15:12] == 4'b1001) begin
                rb_word = {code_of(w[11:10]), 4'b0000};
                rb_pend = 1'b1;
            end
        end
    endtask

    function automatic logic [31:0] rd_cmd(input logic [1:0] ch);
        return {4'b1001, ch, 26'h2AAAAAA};
    endfunction

    initial begin
        void'($urandom(32'h5EED_0042));
        chan_codes = {$urandom(), $urandom()};
        wait_clk(3);
        chk("R7", "reset oe", {31'd0, sdo_oe}, 0);
        chk("R7", "reset sdo", {31'd0, sdo}, 0);
        chk("R2", "reset eoc", {31'd0, eoc}, 0);
        rst_n = 1'b1;
        wait_clk(2);

        // readback, select-release end of frame (R1 R4 R5 R6)
        pin_mode = 2'b00; eoc_at_edge = 1'b0;
        run_frame(32'h1234_0000, 16);       // R6: nothing loaded
        for (int c = 0; c < 4; c++) begin
            run_frame(rd_cmd(2'(c)), 16);   // R4 each channel
            run_frame(32'h0, 16);           // R5 shows code
        end
        run_frame(32'h0, 16);               // R6 consumed
        // R4: last 16 bits decoded in select-release mode
        run_frame({4'h0, 4'b1001, 2'd3, 22'h0}, 20);
        run_frame(32'h0, 20);
        // R4: first 16 bits decoded at 16th edge
        eoc_at_edge = 1'b1;
        run_frame({4'b1001, 2'd1, 26'h3FF_FFFF}, 20);
        run_frame(32'h0, 24);
        // R3: short read frame loads nothing
        run_frame(rd_cmd(2'd2), 12);
        run_frame(32'h0, 16);
        // R6: consumed in another mode
        run_frame(rd_cmd(2'd0), 16);
        pin_mode = 2'b01;
        run_frame(32'hDEAD_BEEF, 32);       // R8 R9
        pin_mode = 2'b00;
        run_frame(32'h0, 16);
        pin_mode = 2'b10;
        run_frame(32'hA5C3_0F96, 32);       // R10
        pin_mode = 2'b11;
        run_frame(32'hFFFF_FFFF, 20);       // R12

        // random frames
        for (int f = 0; f < 60; f++) begin
            logic [31:0] v;
            int n;
            pin_mode    = 2'($urandom_range(0, 3));
            eoc_at_edge = 1'($urandom_range(0, 1));
            n = $urandom_range(8, 32);
            v = $urandom();
            if ($urandom_range(0, 2) == 0) v[31:28] = 4'b1001;
            run_frame(v, n);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule